// File: doc/BRIEF.md
# Precision Time-of-Day Counter with Fractional Accumulator

This block keeps a free-running 64-bit nanosecond time-of-day value for stamping packets. A slow reference clock arrives as a plain input and is sampled in the system clock domain. Each active edge of that reference adds a programmable addend to a 32-bit accumulator. Each carry out of the accumulator moves the nanosecond counter forward by a programmable period. The addend sets the long-run fractional rate. The period is normally 10^9 divided by the nominal frequency, and it must be larger than the reference clock period. With the default period of 1, the counter simply counts accumulator carries.

Software writes the addend, the period, a 64-bit offset and a control word through a simple register port. It can read the same registers back without delay. The reported time is the raw counter plus the offset, added on the read path. A soft-reset control bit clears the timing state (counter, accumulator and divided-clock toggle) but leaves every configuration register as it was. Two further control bits choose which edge of the reference clock is active and whether the divided-clock output is inverted. The divided clock toggles on every counter advance.

Top module: `ptc_top`

## Requirements
- R1: After rst_n the control word reads 0, the addend reads 0, the period reads 1, both offset halves read 0, time_now is 0 and gen_clk_out is 0.
- R2: Each active reference edge adds the addend to the 32-bit accumulator modulo 2^32. A carry out produces exactly one adv_strobe pulse of one cycle, and no strobe occurs without a carry.
- R3: The raw counter changes only on a carry, and then it grows by the period value. In the cycle that adv_strobe is high, time_now already shows the new value.
- R4: A period register value of 0 advances the counter by 1. The register still reads back 0.
- R5: time_now equals the raw counter plus the 64-bit offset {offset_hi, offset_lo}, modulo 2^64. The sum tracks offset writes with no added clock.
- R6: While control bit 1 (soft reset) is set, the counter, the accumulator and the divided-clock toggle hold at zero, and reference edges are ignored. All configuration registers keep their values. Counting resumes with the first active edge after the bit is cleared.
- R7: Control bit 2 selects the active reference edge: 0 selects rising edges of ref_clk_in, 1 selects falling edges.
- R8: The divided-clock toggle flips on every adv_strobe. gen_clk_out is that toggle XOR control bit 3.
- R9: When control bit 0 (enable) is 0, reference edges leave the accumulator and the counter unchanged.
- R10: Register addresses are 0 control, 1 addend, 2 period, 3 offset low word, 4 offset high word. A write takes effect on the clock edge where cfg_we is high. cfg_rdata shows the addressed register combinationally, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| ref_clk_in | input | 1 | Reference clock, sampled through a synchronizer |
| time_now | output | 64 | Counter plus offset |
| adv_strobe | output | 1 | One-cycle pulse on each counter advance |
| gen_clk_out | output | 1 | Divided clock, optionally inverted |

## Verification
The hardest case to reach from the ports is an accumulator carry that lines up with a change of configuration. Examples are an active-edge switch between a rising and a falling edge, a zero period, and a soft reset while the accumulator holds a partial sum. The stimulus reaches these cases by choosing addends such as 0x40000000, 0xC0000000 and 0xFFFFFFFF, which make carries fall on known edge numbers. It moves the reference level one edge at a time, so a bench-side model knows exactly which edge must produce a carry. It changes configuration only between edges and checks every strobe against the value the model queued.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    parameter int REG_W  = 32;
    parameter int ADDR_W = 3;
    localparam int ACC_W = REG_W;
    localparam int CNT_W = 2 * REG_W;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_ADDEND = 3'd1;
    localparam logic [ADDR_W-1:0] A_PERIOD = 3'd2;
    localparam logic [ADDR_W-1:0] A_OFF_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_OFF_HI = 3'd4;

    typedef struct packed {
        logic out_inv;
        logic in_inv;
        logic soft_rst;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t              ctrl;
        logic [REG_W-1:0]   addend;
        logic [REG_W-1:0]   period;
        logic [CNT_W-1:0]   offset;
    } cfg_t;
endpackage

// File: rtl/ptc_cfg_regs.sv
module ptc_cfg_regs
    import ptc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output cfg_t              cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (addr_i)
                A_CTRL:   cfg_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
                A_ADDEND: cfg_d.addend = wdata_i;
                A_PERIOD: cfg_d.period = wdata_i;
                A_OFF_LO: cfg_d.offset[REG_W-1:0] = wdata_i;
                A_OFF_HI: cfg_d.offset[CNT_W-1:REG_W] = wdata_i;
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_comb begin
        case (addr_i)
            A_CTRL:   rdata_o = REG_W'(cfg_q.ctrl);
            A_ADDEND: rdata_o = cfg_q.addend;
            A_PERIOD: rdata_o = cfg_q.period;
            A_OFF_LO: rdata_o = cfg_q.offset[REG_W-1:0];
            A_OFF_HI: rdata_o = cfg_q.offset[CNT_W-1:REG_W];
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            cfg_q.period <= REG_W'(1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // R10: registers move only on a write
    p_cfg_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/ptc_edge_sel.sv
module ptc_edge_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    input  logic in_inv_i,
    input  logic enable_i,
    output logic event_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     lvl_now, lvl_old;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], ref_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (SYNC_STAGES >= 2) begin : g_sync
            assign lvl_now = st_q.chain[SYNC_STAGES-1];
            assign lvl_old = st_q.chain[SYNC_STAGES];
        end else begin : g_nosync
            assign lvl_now = st_q.chain[0];
            assign lvl_old = st_q.chain[1];
        end
    endgenerate

    assign event_o = enable_i &&
                     (in_inv_i ? (lvl_old && !lvl_now) : (lvl_now && !lvl_old));
endmodule

// File: rtl/ptc_accum.sv
module ptc_accum
    import ptc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst_i,
    input  logic             event_i,
    input  logic [REG_W-1:0] addend_i,
    input  logic [REG_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             adv_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic             adv;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [ACC_W:0]   sum_w;
    logic [CNT_W-1:0] step_w;

    always_comb begin
        sum_w  = {1'b0, st_q.acc} + {1'b0, addend_i};
        step_w = (period_i == '0) ? CNT_W'(1) : CNT_W'(period_i);
        st_d     = st_q;
        st_d.adv = 1'b0;
        if (srst_i) begin
            st_d = '0;
        end else if (event_i) begin
            st_d.acc = sum_w[ACC_W-1:0];
            st_d.adv = sum_w[ACC_W];
            if (sum_w[ACC_W]) st_d.cnt = st_q.cnt + step_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign adv_o = st_q.adv;

    // R6: soft reset holds timing state at zero
    p_srst_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (st_q.cnt == '0 && st_q.acc == '0 && !st_q.adv));
    // R2: a strobe only follows a reference event
    p_adv_needs_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.adv |-> $past(event_i));
    // R3: counter moves by the step on an advance
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.adv |-> st_q.cnt == $past(st_q.cnt) + $past(step_w));
    // R3: counter holds without an advance
    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.adv && !$past(srst_i)) |-> $stable(st_q.cnt));
    // R9: accumulator idle without an event
    p_acc_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!event_i && !srst_i) |=> $stable(st_q.acc));
endmodule

// File: rtl/ptc_time_out.sv
module ptc_time_out
    import ptc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst_i,
    input  logic             adv_i,
    input  logic             out_inv_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] offset_i,
    output logic [CNT_W-1:0] time_o,
    output logic             gen_clk_o
);
    typedef struct packed {
        logic tog;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (srst_i)     st_d.tog = 1'b0;
        else if (adv_i) st_d.tog = !st_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign time_o    = cnt_i + offset_i;
    assign gen_clk_o = st_q.tog ^ out_inv_i;

    // R8: toggle flips once per advance
    p_gen_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !srst_i) |=> st_q.tog != $past(st_q.tog));
endmodule

// File: rtl/ptc_top.sv
module ptc_top
    import ptc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              ref_clk_in,
    output logic [CNT_W-1:0]  time_now,
    output logic              adv_strobe,
    output logic              gen_clk_out
);
    cfg_t             cfg;
    logic             ref_event;
    logic [CNT_W-1:0] raw_cnt;

    ptc_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .cfg_o   (cfg)
    );

    ptc_edge_sel #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_i    (ref_clk_in),
        .in_inv_i (cfg.ctrl.in_inv),
        .enable_i (cfg.ctrl.enable),
        .event_o  (ref_event)
    );

    ptc_accum u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst_i   (cfg.ctrl.soft_rst),
        .event_i  (ref_event),
        .addend_i (cfg.addend),
        .period_i (cfg.period),
        .cnt_o    (raw_cnt),
        .adv_o    (adv_strobe)
    );

    ptc_time_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_i    (cfg.ctrl.soft_rst),
        .adv_i     (adv_strobe),
        .out_inv_i (cfg.ctrl.out_inv),
        .cnt_i     (raw_cnt),
        .offset_i  (cfg.offset),
        .time_o    (time_now),
        .gen_clk_o (gen_clk_out)
    );
endmodule

// File: tb/test_ptc_top.sv
module test_ptc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ref_clk_in = 1'b0;
    logic [63:0] time_now;
    logic        adv_strobe;
    logic        gen_clk_out;

    int n_chk = 0, n_fail = 0, n_exp = 0, n_seen = 0;
    bit done = 0;
    logic [63:0] exp_q[$];

    logic [31:0] m_acc = 0, m_add = 0, m_per = 1;
    logic [63:0] m_cnt = 0, m_off = 0;
    logic [3:0]  m_ctrl = 0;
    logic        m_tog = 0;

    always #10 clk = ~clk;

    ptc_top i_ptc_top (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        case (a)
            3'd0: begin
                m_ctrl = d[3:0];
                if (d[1]) begin m_acc = 0; m_cnt = 0; m_tog = 0; end
            end
            3'd1: m_add = d;
            3'd2: m_per = d;
            3'd3: m_off[31:0] = d;
            3'd4: m_off[63:32] = d;
            default: ;
        endcase
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(cfg_rdata == e, tag, 64'(cfg_rdata), 64'(e));
    endtask

    task automatic ref_to(input logic v);
        logic [32:0] s;
        bit act;
        act = (v != ref_clk_in) && m_ctrl[0] && !m_ctrl[1] && (m_ctrl[2] ? !v : v);
        if (act) begin
            s = {1'b0, m_acc} + {1'b0, m_add};
            m_acc = s[31:0];
            if (s[32]) begin
                m_cnt = m_cnt + ((m_per == 0) ? 64'd1 : 64'(m_per));
                m_tog = !m_tog;
                exp_q.push_back(m_cnt + m_off);
                n_exp++;
            end
        end
        @(negedge clk);
        ref_clk_in = v;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ref_to(1'b1);
            ref_to(1'b0);
        end
    endtask

    task automatic quiet_check(input string tag);
        chk(time_now == m_cnt + m_off, {tag, " time"}, time_now, m_cnt + m_off);
        chk(gen_clk_out == (m_tog ^ m_ctrl[3]), {tag, " gen_clk"}, 64'(gen_clk_out), 64'(m_tog ^ m_ctrl[3]));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && adv_strobe) begin
            n_seen++;
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected strobe", time_now, 0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                chk(time_now == e, "R3 time at strobe", time_now, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 / R10 reset state and map
        rd(3'd0, 0, "R1 ctrl");
        rd(3'd1, 0, "R1 addend");
        rd(3'd2, 1, "R1 period");
        rd(3'd3, 0, "R1 off_lo");
        rd(3'd4, 0, "R1 off_hi");
        rd(3'd6, 0, "R10 unused addr");
        quiet_check("R1");

        // R2 default period counts carries
        wr(3'd1, 32'h8000_0000);
        wr(3'd0, 32'h1);
        pulses(4);
        quiet_check("R2 period1");

        // R3 period 8, carry every 4th edge
        wr(3'd1, 32'h4000_0000);
        wr(3'd2, 32'd8);
        pulses(10);
        quiet_check("R3 period8");
        rd(3'd2, 8, "R10 period readback");

        // R9 disabled
        wr(3'd0, 32'h0);
        pulses(5);
        quiet_check("R9 disabled");

        // R7 falling edge active
        wr(3'd0, 32'h5);
        wr(3'd1, 32'hC000_0000);
        ref_to(1'b1);
        quiet_check("R7 rise ignored");
        pulses(6);
        quiet_check("R7 falling");

        // R8 inverted output
        wr(3'd0, 32'hD);
        quiet_check("R8 inverted");

        // R4 zero period
        wr(3'd2, 32'd0);
        wr(3'd1, 32'hFFFF_FFFF);
        pulses(5);
        rd(3'd2, 0, "R4 period reads 0");
        quiet_check("R4 step one");

        // R5 offset with wrap
        wr(3'd3, 32'hFFFF_FFF0);
        wr(3'd4, 32'hFFFF_FFFF);
        quiet_check("R5 offset wrap");
        pulses(4);
        quiet_check("R5 after counting");

        // R6 soft reset keeps config
        wr(3'd0, 32'hF);
        pulses(3);
        quiet_check("R6 held");
        rd(3'd1, 32'hFFFF_FFFF, "R6 addend kept");
        rd(3'd3, 32'hFFFF_FFF0, "R6 offset kept");
        rd(3'd0, 32'hF, "R6 ctrl kept");
        wr(3'd0, 32'h1);
        wr(3'd2, 32'd100);
        pulses(4);
        quiet_check("R6 resumed");

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R2 pending strobes", 64'(exp_q.size()), 0);
        chk(n_seen == n_exp, "R2 strobe count", 64'(n_seen), 64'(n_exp));
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule